// File: doc/BRIEF.md
# Nibble-Programmed Cartridge Bank Controller

This block watches CPU writes in the upper half of a 16-bit address space and turns them into bank-selection state for a game cartridge. It holds two program bank numbers, one for each switchable 8 KB window at 0x8000 and 0xA000. The window at 0xC000 is fixed to the last 16 KB bank of the ROM. The block also keeps eight 1 KB pattern-memory bank numbers, a nametable mirroring mode and a flag that selects pattern RAM or pattern ROM.

Each pattern bank is loaded with two writes, one for each nibble of an 8-bit staging value. A write to the high nibble can also add extra bank bits, taken from the top four data bits. Two particular bank values are never stored as banks. They are commands that set or clear the RAM/ROM flag. Memory arrays and any interrupt timer sit outside this block. Their address inputs are driven from the outputs here.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the 0x8000 window holds 8 KB bank 0 and the 0xA000 window holds bank 1. Pattern bank i holds value i, and its staging byte also holds i. Mirroring is 0 and the RAM/ROM flag is 0.
- R2: A write to exactly 0x8010 loads the 0x8000 window bank with the 8 data bits. A write to exactly 0xA010 loads the 0xA000 window bank the same way.
- R3: The bank numbers for the 0xC000 and 0xE000 windows are 2*(rom_banks16-1) and 2*(rom_banks16-1)+1. They follow the ROM size input without waiting for a clock.
- R4: A write to exactly 0x9400 sets the mirroring mode to data bits 1:0, where 0 is vertical, 1 is horizontal, 2 is single-screen page 0 and 3 is single-screen page 1. The other data bits are ignored.
- R5: A pattern register is decoded only from address bits 15:12 (values 0xB to 0xE) and bits 3:2. The register index is 2*(bits15:12 - 0xB) + bit 3. Bit 2 selects the nibble: 0 is low, 1 is high. Address bits 11:4 and 1:0 are ignored.
- R6: On a low-nibble write, data bits 3:0 replace bits 3:0 of the staging byte. The effective bank value is then the staging byte zero-extended to 12 bits.
- R7: On a high-nibble write, data bits 3:0 replace bits 7:4 of the staging byte. The effective bank value is then data bits 7:4 times 256 plus the staging byte.
- R8: An effective value of 0x088 clears the RAM/ROM flag, and 0x0C8 sets it. In both cases the bank output keeps its old value while the staging byte still updates. Any other effective value is loaded into the bank output.
- R9: A write to any address not listed above, or bus activity while the write strobe is low, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe; the write takes effect at the clock edge |
| rom_banks16 | input | 8 | ROM size counted in 16 KB units (at least 1) |
| prg_bank_8000 | output | 9 | 8 KB bank number for the 0x8000 window |
| prg_bank_a000 | output | 9 | 8 KB bank number for the 0xA000 window |
| prg_bank_c000 | output | 9 | 8 KB bank number for the 0xC000 window |
| prg_bank_e000 | output | 9 | 8 KB bank number for the 0xE000 window |
| chr_banks | output | 96 | Eight 12-bit pattern bank numbers; slot i sits in bits 12*i+11 down to 12*i |
| mirror_mode | output | 2 | Nametable mirroring mode |
| chr_ram_sel | output | 1 | 1 selects pattern RAM, 0 selects pattern ROM |

## Verification
The bench builds the block with its default parameters: an 8-bit ROM size input and 9-bit program bank numbers. With these values a ROM size of 255 pushes the fixed-window bank numbers to 508 and 509, which uses the top bit of the output, and a size of 1 sets them to 0 and 1. The 12-bit pattern width lets high-nibble writes put nonzero values in bits 11:8. The same width lets the bench show that 0x1C8 is loaded as an ordinary bank while 0x0C8 is treated as a command. Each pattern write is followed by a check of all eight slots and the flag, so a write that reaches the wrong slot is caught.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int CHR_SLOTS = 8;
  localparam int STAGE_W   = 8;
  localparam int EXT_W     = 4;
  localparam int CHR_W     = STAGE_W + EXT_W;
  localparam int IDX_W     = $clog2(CHR_SLOTS);

  localparam logic [CHR_W-1:0]  CMD_ROM   = 12'h088;
  localparam logic [CHR_W-1:0]  CMD_RAM   = 12'h0C8;
  localparam logic [ADDR_W-1:0] ADR_PRG_A = 16'h8010;
  localparam logic [ADDR_W-1:0] ADR_PRG_B = 16'hA010;
  localparam logic [ADDR_W-1:0] ADR_MIRR  = 16'h9400;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_ONE0 = 2'd2,
    MIR_ONE1 = 2'd3
  } mirror_e;

  typedef struct packed {
    logic                 prg_a;
    logic                 prg_b;
    logic                 mirr;
    logic [CHR_SLOTS-1:0] chr_hit;
    logic                 chr_hi;
  } wr_dec_t;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wr_dec_t           dec
);
  logic [3:0]       page;
  logic [IDX_W-1:0] idx;

  always_comb begin
    page = addr[15:12] - 4'hB;
    idx  = {page[1:0], addr[3]};
    dec  = '0;
    if (wr) begin
      dec.prg_a  = (addr == ADR_PRG_A);
      dec.prg_b  = (addr == ADR_PRG_B);
      dec.mirr   = (addr == ADR_MIRR);
      dec.chr_hi = addr[2];
      if (addr[15:12] >= 4'hB && addr[15:12] <= 4'hE)
        dec.chr_hit[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/cbc_chr_slot.sv
module cbc_chr_slot
  import cbc_pkg::*;
#(
  parameter int RESET_VAL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              hi_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [CHR_W-1:0]  bank_o,
  output logic              cmd_rom_o,
  output logic              cmd_ram_o
);
  logic [STAGE_W-1:0] stage_q, stage_nx;
  logic [CHR_W-1:0]   bank_q, bank_nx, eff;

  always_comb begin
    stage_nx = hi_sel ? {wdata[3:0], stage_q[3:0]} : {stage_q[7:4], wdata[3:0]};
    eff      = hi_sel ? {wdata[7:4], stage_nx} : {{EXT_W{1'b0}}, stage_nx};
    cmd_rom_o = hit && (eff == CMD_ROM);
    cmd_ram_o = hit && (eff == CMD_RAM);
    bank_nx  = (cmd_rom_o || cmd_ram_o) ? bank_q : eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STAGE_W'(RESET_VAL);
      bank_q  <= CHR_W'(RESET_VAL);
    end else if (hit) begin
      stage_q <= stage_nx;
      bank_q  <= bank_nx;
    end
  end

  assign bank_o = bank_q;

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bank_o) && $stable(stage_q));
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rom_o || cmd_ram_o) |=> $stable(bank_o));
  p_hi_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hi_sel && !cmd_rom_o && !cmd_ram_o) |=>
      (bank_o[11:8] == $past(wdata[7:4])) && (bank_o[7:4] == $past(wdata[3:0])));
  p_lo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hi_sel && !cmd_rom_o && !cmd_ram_o) |=>
      (bank_o[11:8] == 4'h0) && (bank_o[3:0] == $past(wdata[3:0])));
endmodule

// File: rtl/cbc_prg_regs.sv
module cbc_prg_regs
  import cbc_pkg::*;
#(
  parameter int ROM_W = 8,
  localparam int PRG_W = ROM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_mirr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROM_W-1:0]  rom_banks16,
  output logic [PRG_W-1:0]  bank_a,
  output logic [PRG_W-1:0]  bank_b,
  output logic [PRG_W-1:0]  bank_c,
  output logic [PRG_W-1:0]  bank_e,
  output logic [1:0]        mirror_o
);
  logic [PRG_W-1:0] a_q, b_q;
  mirror_e          mir_q;
  logic [ROM_W-1:0] last16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= PRG_W'(0);
      b_q   <= PRG_W'(1);
      mir_q <= MIR_VERT;
    end else begin
      if (ld_a)    a_q   <= PRG_W'(wdata);
      if (ld_b)    b_q   <= PRG_W'(wdata);
      if (ld_mirr) mir_q <= mirror_e'(wdata[1:0]);
    end
  end

  always_comb begin
    last16 = rom_banks16 - ROM_W'(1);
    bank_c = {last16, 1'b0};
    bank_e = {last16, 1'b1};
  end

  assign bank_a   = a_q;
  assign bank_b   = b_q;
  assign mirror_o = mir_q;

  p_prg_a_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> bank_a == PRG_W'($past(wdata)));
  p_prg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a && !ld_b) |=> $stable(bank_a) && $stable(bank_b));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_W = 8,
  localparam int PRG_W = ROM_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_data,
  input  logic                       cpu_wr,
  input  logic [ROM_W-1:0]           rom_banks16,
  output logic [PRG_W-1:0]           prg_bank_8000,
  output logic [PRG_W-1:0]           prg_bank_a000,
  output logic [PRG_W-1:0]           prg_bank_c000,
  output logic [PRG_W-1:0]           prg_bank_e000,
  output logic [CHR_SLOTS*CHR_W-1:0] chr_banks,
  output logic [1:0]                 mirror_mode,
  output logic                       chr_ram_sel
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  wr_dec_t              dec;
  logic [CHR_SLOTS-1:0] rom_cmd, ram_cmd;
  logic                 flag_q, flag_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cbc_decode u_dec (
    .addr (cpu_addr),
    .wr   (cpu_wr),
    .dec  (dec)
  );

  cbc_prg_regs #(.ROM_W(ROM_W)) u_prg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ld_a        (dec.prg_a),
    .ld_b        (dec.prg_b),
    .ld_mirr     (dec.mirr),
    .wdata       (cpu_data),
    .rom_banks16 (rom_banks16),
    .bank_a      (prg_bank_8000),
    .bank_b      (prg_bank_a000),
    .bank_c      (prg_bank_c000),
    .bank_e      (prg_bank_e000),
    .mirror_o    (mirror_mode)
  );

  for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_slot
    cbc_chr_slot #(.RESET_VAL(g)) u_slot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .hit       (dec.chr_hit[g]),
      .hi_sel    (dec.chr_hi),
      .wdata     (cpu_data),
      .bank_o    (chr_banks[g*CHR_W +: CHR_W]),
      .cmd_rom_o (rom_cmd[g]),
      .cmd_ram_o (ram_cmd[g])
    );
  end

  always_comb begin
    flag_nx = flag_q;
    if (|ram_cmd)      flag_nx = 1'b1;
    else if (|rom_cmd) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flag_q <= 1'b0;
    else            flag_q <= flag_nx;
  end

  assign chr_ram_sel = flag_q;

  p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(dec.chr_hit));
  p_flag_ram_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|ram_cmd) |=> chr_ram_sel);
  p_flag_rom_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|rom_cmd) |=> !chr_ram_sel);
  p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && cpu_addr == 16'h9400) |=> mirror_mode == $past(cpu_data[1:0]));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cpu_wr |=> $stable(chr_banks) && $stable(mirror_mode) && $stable(chr_ram_sel));
endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic [7:0]  rom_banks16;
  logic [8:0]  prg_bank_8000, prg_bank_a000, prg_bank_c000, prg_bank_e000;
  logic [95:0] chr_banks;
  logic [1:0]  mirror_mode;
  logic        chr_ram_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0]  m_stage [8];
  logic [11:0] m_bank  [8];
  logic        m_flag;
  logic [8:0]  m_pa, m_pb;
  logic [1:0]  m_mir;

  always #4 clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .rom_banks16(rom_banks16),
    .prg_bank_8000(prg_bank_8000), .prg_bank_a000(prg_bank_a000),
    .prg_bank_c000(prg_bank_c000), .prg_bank_e000(prg_bank_e000),
    .chr_banks(chr_banks), .mirror_mode(mirror_mode), .chr_ram_sel(chr_ram_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic chk_state(input string req);
    for (int i = 0; i < 8; i++) chk(req, 32'(chr_banks[i*12 +: 12]), 32'(m_bank[i]));
    chk(req, 32'(chr_ram_sel), 32'(m_flag));
    chk(req, 32'(prg_bank_8000), 32'(m_pa));
    chk(req, 32'(prg_bank_a000), 32'(m_pb));
    chk(req, 32'(mirror_mode), 32'(m_mir));
  endtask

  task automatic chr_wr(input int idx, input bit hi, input logic [7:0] d, input logic [7:0] junk);
    logic [15:0] a;
    logic [11:0] eff;
    a = {4'(4'hB + idx / 2), junk, 1'(idx % 2), hi, 2'b00};
    if (hi) m_stage[idx] = {d[3:0], m_stage[idx][3:0]};
    else    m_stage[idx] = {m_stage[idx][7:4], d[3:0]};
    eff = hi ? {d[7:4], m_stage[idx]} : {4'h0, m_stage[idx]};
    if (eff == 12'h088)      m_flag = 1'b0;
    else if (eff == 12'h0C8) m_flag = 1'b1;
    else                     m_bank[idx] = eff;
    bus_wr(a, d);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) begin
      m_stage[i] = 8'(i); m_bank[i] = 12'(i);
    end
    m_flag = 1'b0; m_pa = 9'd0; m_pb = 9'd1; m_mir = 2'd0;
    chk_state("R1 reset");
  endtask

  task automatic t_prg;
    bus_wr(16'h8010, 8'h5A); m_pa = 9'h05A; chk_state("R2 prg 8000");
    bus_wr(16'hA010, 8'hFF); m_pb = 9'h0FF; chk_state("R2 prg A000");
    bus_wr(16'h8011, 8'h33); chk_state("R9 near miss 8011");
    bus_wr(16'h8000, 8'h44); chk_state("R9 near miss 8000");
  endtask

  task automatic t_fixed;
    rom_banks16 = 8'd1;   #1; chk("R3 c000 size1", 32'(prg_bank_c000), 0);
    chk("R3 e000 size1", 32'(prg_bank_e000), 1);
    rom_banks16 = 8'd128; #1; chk("R3 c000 size128", 32'(prg_bank_c000), 254);
    chk("R3 e000 size128", 32'(prg_bank_e000), 255);
    rom_banks16 = 8'd255; #1; chk("R3 c000 size255", 32'(prg_bank_c000), 508);
    chk("R3 e000 size255", 32'(prg_bank_e000), 509);
  endtask

  task automatic t_mirror;
    for (int m = 3; m >= 0; m--) begin
      bus_wr(16'h9400, {6'b101010, 2'(m)}); m_mir = 2'(m);
      chk_state("R4 mirroring");
    end
    bus_wr(16'h9401, 8'h03); chk_state("R9 mirror near miss");
    bus_wr(16'h9400, 8'hFD); m_mir = 2'd1; chk_state("R4 mirror upper bits");
  endtask

  task automatic t_chr_low;
    for (int i = 0; i < 8; i++) begin
      chr_wr(i, 1'b0, 8'hF0 | 8'(i + 3), 8'(i * 37));
      chk_state("R6 R5 low nibble");
    end
  endtask

  task automatic t_chr_high;
    for (int i = 0; i < 8; i++) begin
      chr_wr(i, 1'b1, 8'(8'h10 * (i + 1)) | 8'(7 - i), 8'hA5 ^ 8'(i));
      chk_state("R7 R5 high nibble");
    end
  endtask

  task automatic t_cmd;
    chr_wr(2, 1'b0, 8'h08, 8'h00); chk_state("R8 setup");
    chr_wr(2, 1'b1, 8'h0C, 8'h00); chk_state("R8 ram cmd");
    chk("R8 flag set", 32'(chr_ram_sel), 1);
    chr_wr(2, 1'b1, 8'h08, 8'h11); chk_state("R8 rom cmd");
    chk("R8 flag clear", 32'(chr_ram_sel), 0);
    chr_wr(2, 1'b1, 8'h1C, 8'h00); chk_state("R8 extended not cmd");
    chk("R8 bank 1C8", 32'(chr_banks[2*12 +: 12]), 32'h1C8);
    chr_wr(2, 1'b0, 8'h08, 8'h00); chk_state("R8 low-write cmd");
    chk("R8 bank kept", 32'(chr_banks[2*12 +: 12]), 32'h1C8);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    cpu_addr = 16'hB00C; cpu_data = 8'h77; cpu_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_state("R9 strobe low");
    bus_wr(16'hF000, 8'h12); chk_state("R9 F000");
    bus_wr(16'hA00C, 8'h34); chk_state("R9 A00C");
    bus_wr(16'h7FFF, 8'h56); chk_state("R9 7FFF");
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0; rom_banks16 = 8'd16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_prg;
    t_fixed;
    t_mirror;
    t_chr_low;
    t_chr_high;
    t_cmd;
    t_ignore;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule